// File: doc/BRIEF.md
# Fault-First Vector Load Unit

This unit carries out one sequential, unit-stride vector load per request. A request gives a byte base address, the number of elements wanted, an element width, a destination vector register and a truncation policy. The unit issues one element read per accepted cycle on a simple read port. The port answers in the same cycle with data and a permission fault flag. Each element that reads cleanly is written into the destination register through a register-file write port, at the matching element index.

The load is allowed to end early. It always stops in front of the first faulting element. Depending on the selected policy, it may also stop at the last element that lies wholly inside the starting page, or at the next batch-aligned address. The number of elements actually loaded is then published for later instructions, either as a replacement vector length or as a mask of loaded elements. A fault on the very first element cannot be absorbed this way. It becomes a real trap that carries the faulting address and updates nothing.

Top module: `ffload_unit`

## Requirements
- R1: Element i is read from address base + i·w, where w is the element width in bytes. At most one read is accepted per cycle. Each cleanly read element i is written to element index i of the requested destination register, and the write carries the low w bytes of the read data, zero-extended.
- R2: With no fault and no truncation, the reported count equals the requested count. done is high for exactly one cycle, the cycle after the last accepted read.
- R3: If the read of element i>0 faults, no further read is issued and no trap is raised. done reports count i in the next cycle, and elements at index i and above are never written.
- R4: If element 0 faults, trap pulses for one cycle in the next cycle with trap_addr equal to the base address. done, the length and mask updates, and register writes all stay low.
- R5: With req_report=0, the final count is written as a vector length (vl_we and vl_value). With req_report=1, mask_we pulses and loaded_mask has bits [count-1:0] set and all other bits clear. The two update strobes are never high together.
- R6: With req_mode=1 (page stop), the load ends after the last element that lies wholly inside the page of the base address. If no element fits wholly, exactly one element is attempted.
- R7: With req_mode=2 (alignment stop) and a base that is not a multiple of BATCH_BYTES, the load is capped at (BATCH_BYTES − base mod BATCH_BYTES) / w elements, rounded down and raised to at least one. An aligned base is not capped. req_mode 0 and 3 apply no cap except faults.
- R8: The reported count never exceeds the requested count and is nonzero whenever the request is nonzero.
- R9: A request for zero elements issues no read and reports count 0 with done in the next cycle.
- R10: While a read is pending and mem_rd_ready is low, the read stays pending with an unchanged address.
- R11: req_esize encodes the element width as 0=1, 1=2, 2=4, 3=8 bytes. mem_rd_size carries the same code.
- R12: busy is high while a load is in progress. req_valid is ignored while busy, and the unit is idle with no read pending in the cycle after done or trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a load (taken only when idle) |
| req_base | input | ADDR_W | Byte address of element 0 |
| req_count | input | CNT_W | Requested element count, 0..MAX_ELEMS |
| req_esize | input | 2 | Element width code |
| req_mode | input | 2 | Truncation policy: 0 fault only, 1 page stop, 2 alignment stop, 3 as 0 |
| req_report | input | 1 | 0 publish length, 1 publish mask |
| req_dest | input | REG_W | Destination vector register |
| busy | output | 1 | Load in progress |
| mem_rd_valid | output | 1 | Element read pending |
| mem_rd_ready | input | 1 | Read accepted this cycle |
| mem_rd_addr | output | ADDR_W | Element byte address |
| mem_rd_size | output | 2 | Element width code |
| mem_rd_data | input | DATA_W | Read data, element in low bytes |
| mem_rd_fault | input | 1 | Permission fault for this read |
| vrf_we | output | 1 | Register element write |
| vrf_reg | output | REG_W | Written register |
| vrf_elem | output | IDX_W | Written element index |
| vrf_wdata | output | DATA_W | Zero-extended element |
| done | output | 1 | Load finished, count valid |
| done_count | output | CNT_W | Elements loaded |
| vl_we | output | 1 | Vector length update |
| vl_value | output | CNT_W | New vector length |
| mask_we | output | 1 | Loaded-element mask update |
| loaded_mask | output | MAX_ELEMS | One bit per loaded element |
| trap | output | 1 | Element 0 faulted |
| trap_addr | output | ADDR_W | Faulting address |

## Verification
The bench builds the unit with 16-bit addresses, eight elements, 64-byte pages and 16-byte batches. At that page size, a page crossing falls inside a single load for every element width and for bases near the end of a page. The bench sweeps all four widths, all four policy codes, six bases around page and batch edges, every count from 0 to 8, and three fault placements: none, a fault two elements in (or on element 0), and a fault on the next page. Back-pressure on the read port, stray requests while busy, and both report forms are mixed into the sweep, and every outcome is predicted arithmetically.

// File: rtl/ffload_pkg.sv
package ffload_pkg;

    typedef enum logic [1:0] {
        MODE_FAULT = 2'd0,
        MODE_PAGE  = 2'd1,
        MODE_ALIGN = 2'd2,
        MODE_RSVD  = 2'd3
    } trunc_mode_e;

    typedef enum logic {
        REPORT_VL   = 1'b0,
        REPORT_MASK = 1'b1
    } report_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // element width in bytes from its 2-bit code
    function automatic logic [3:0] esize_step(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

    // true when byte lane b belongs to an element of width code
    function automatic logic lane_kept(input logic [1:0] code, input int b);
        return b < (1 << code);
    endfunction

endpackage

// File: rtl/ffload_limit.sv
module ffload_limit
    import ffload_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 5,
    parameter int PAGE_BYTES  = 4096,
    parameter int BATCH_BYTES = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        esz,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        mode,
    output logic [CNT_W-1:0]  limit
);
    localparam int RW = ADDR_W + 1;

    logic [RW-1:0] page_room, batch_room, cand;
    logic [ADDR_W-1:0] page_off, batch_off;

    always_comb begin
        page_off   = base & ADDR_W'(PAGE_BYTES - 1);
        batch_off  = base & ADDR_W'(BATCH_BYTES - 1);
        page_room  = RW'(PAGE_BYTES) - RW'(page_off);
        batch_room = RW'(BATCH_BYTES) - RW'(batch_off);
        case (mode)
            MODE_PAGE:  cand = page_room >> esz;
            MODE_ALIGN: cand = (batch_off == '0) ? RW'(count) : (batch_room >> esz);
            default:    cand = RW'(count);
        endcase
        if (cand == '0) begin
            cand = RW'(1);
        end
        limit = (RW'(count) < cand) ? count : CNT_W'(cand);
    end

endmodule

// File: rtl/ffload_report.sv
module ffload_report #(
    parameter int MAX_ELEMS = 16,
    parameter int CNT_W     = 5
) (
    input  logic [CNT_W-1:0]     count,
    output logic [MAX_ELEMS-1:0] mask
);
    for (genvar i = 0; i < MAX_ELEMS; i++) begin : g_bit
        assign mask[i] = count > CNT_W'(i);
    end
endmodule

// File: rtl/ffload_seq.sv
module ffload_seq
    import ffload_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int CNT_W      = 5,
    parameter int IDX_W      = 4,
    parameter int REG_W      = 5,
    parameter int PAGE_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [1:0]        req_esize,
    input  logic [1:0]        req_mode,
    input  logic              req_report,
    input  logic [REG_W-1:0]  req_dest,
    input  logic [CNT_W-1:0]  req_limit,
    output logic              busy,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [1:0]        mem_rd_size,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_fault,
    output logic              vrf_we,
    output logic [REG_W-1:0]  vrf_reg,
    output logic [IDX_W-1:0]  vrf_elem,
    output logic [DATA_W-1:0] vrf_wdata,
    output logic              fin_valid,
    output logic [CNT_W-1:0]  fin_count,
    output logic              fin_report,
    output logic              trap,
    output logic [ADDR_W-1:0] trap_addr
);
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int PAGE_SH    = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] base;
        logic [1:0]        esz;
        logic [1:0]        mode;
        logic              report;
        logic [REG_W-1:0]  dest;
        logic [CNT_W-1:0]  limit;
        logic [CNT_W-1:0]  asked;
    } job_t;

    seq_state_e       state;
    job_t             job;
    logic [CNT_W-1:0] idx_q, idx_nx;
    logic             hs, last;
    logic [DATA_W-1:0] elem_data;

    assign idx_nx       = idx_q + CNT_W'(1);
    assign last         = (idx_nx == job.limit);
    assign hs           = (state == ST_RUN) && mem_rd_ready;
    assign busy         = (state == ST_RUN);
    assign mem_rd_valid = (state == ST_RUN);
    assign mem_rd_addr  = job.addr;
    assign mem_rd_size  = job.esz;
    assign fin_report   = job.report;

    always_comb begin
        for (int b = 0; b < DATA_BYTES; b++) begin
            elem_data[b*8 +: 8] = lane_kept(job.esz, b) ? mem_rd_data[b*8 +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            job       <= '0;
            idx_q     <= '0;
            vrf_we    <= 1'b0;
            vrf_reg   <= '0;
            vrf_elem  <= '0;
            vrf_wdata <= '0;
            fin_valid <= 1'b0;
            fin_count <= '0;
            trap      <= 1'b0;
            trap_addr <= '0;
        end else begin
            vrf_we    <= 1'b0;
            fin_valid <= 1'b0;
            trap      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        job.addr   <= req_base;
                        job.base   <= req_base;
                        job.esz    <= req_esize;
                        job.mode   <= req_mode;
                        job.report <= req_report;
                        job.dest   <= req_dest;
                        job.limit  <= req_limit;
                        job.asked  <= req_count;
                        idx_q      <= '0;
                        if (req_limit == '0) begin
                            fin_valid <= 1'b1;
                            fin_count <= '0;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (hs) begin
                        if (mem_rd_fault) begin
                            state <= ST_IDLE;
                            if (idx_q == '0) begin
                                trap      <= 1'b1;
                                trap_addr <= job.addr;
                            end else begin
                                fin_valid <= 1'b1;
                                fin_count <= idx_q;
                            end
                        end else begin
                            vrf_we    <= 1'b1;
                            vrf_reg   <= job.dest;
                            vrf_elem  <= IDX_W'(idx_q);
                            vrf_wdata <= elem_data;
                            idx_q     <= idx_nx;
                            job.addr  <= job.addr + ADDR_W'(esize_step(job.esz));
                            if (last) begin
                                state     <= ST_IDLE;
                                fin_valid <= 1'b1;
                                fin_count <= idx_nx;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && mem_rd_ready && !mem_rd_fault && !last
        |=> mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(esize_step(mem_rd_size)));

    assert_count_bounds_R8: assert property (@(posedge clk) disable iff (rst)
        fin_valid |-> (fin_count <= job.asked) && (fin_count != '0 || job.asked == '0));

    assert_trap_alone_R4: assert property (@(posedge clk) disable iff (rst)
        trap |-> !fin_valid && !vrf_we);

    assert_page_stay_R6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && job.mode == MODE_PAGE && idx_q != '0
        |-> (mem_rd_addr >> PAGE_SH) == (job.base >> PAGE_SH));

endmodule

// File: rtl/ffload_unit.sv
module ffload_unit
    import ffload_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int MAX_ELEMS   = 16,
    parameter int PAGE_BYTES  = 4096,
    parameter int BATCH_BYTES = 64,
    parameter int REG_W       = 5,
    localparam int CNT_W      = $clog2(MAX_ELEMS + 1),
    localparam int IDX_W      = $clog2(MAX_ELEMS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [CNT_W-1:0]     req_count,
    input  logic [1:0]           req_esize,
    input  logic [1:0]           req_mode,
    input  logic                 req_report,
    input  logic [REG_W-1:0]     req_dest,
    output logic                 busy,
    output logic                 mem_rd_valid,
    input  logic                 mem_rd_ready,
    output logic [ADDR_W-1:0]    mem_rd_addr,
    output logic [1:0]           mem_rd_size,
    input  logic [DATA_W-1:0]    mem_rd_data,
    input  logic                 mem_rd_fault,
    output logic                 vrf_we,
    output logic [REG_W-1:0]     vrf_reg,
    output logic [IDX_W-1:0]     vrf_elem,
    output logic [DATA_W-1:0]    vrf_wdata,
    output logic                 done,
    output logic [CNT_W-1:0]     done_count,
    output logic                 vl_we,
    output logic [CNT_W-1:0]     vl_value,
    output logic                 mask_we,
    output logic [MAX_ELEMS-1:0] loaded_mask,
    output logic                 trap,
    output logic [ADDR_W-1:0]    trap_addr
);
    logic [CNT_W-1:0]     limit;
    logic                 fin_valid, fin_report;
    logic [CNT_W-1:0]     fin_count;
    logic [MAX_ELEMS-1:0] mask_raw;

    ffload_limit #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .PAGE_BYTES(PAGE_BYTES), .BATCH_BYTES(BATCH_BYTES)
    ) u_limit (
        .base(req_base), .esz(req_esize), .count(req_count),
        .mode(req_mode), .limit(limit)
    );

    ffload_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W),
        .REG_W(REG_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_base(req_base), .req_count(req_count),
        .req_esize(req_esize), .req_mode(req_mode), .req_report(req_report),
        .req_dest(req_dest), .req_limit(limit), .busy(busy),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr), .mem_rd_size(mem_rd_size),
        .mem_rd_data(mem_rd_data), .mem_rd_fault(mem_rd_fault),
        .vrf_we(vrf_we), .vrf_reg(vrf_reg), .vrf_elem(vrf_elem), .vrf_wdata(vrf_wdata),
        .fin_valid(fin_valid), .fin_count(fin_count), .fin_report(fin_report),
        .trap(trap), .trap_addr(trap_addr)
    );

    ffload_report #(.MAX_ELEMS(MAX_ELEMS), .CNT_W(CNT_W)) u_report (
        .count(fin_count), .mask(mask_raw)
    );

    assign done        = fin_valid;
    assign done_count  = fin_count;
    assign vl_we       = fin_valid && (fin_report == REPORT_VL);
    assign vl_value    = fin_count;
    assign mask_we     = fin_valid && (fin_report == REPORT_MASK);
    assign loaded_mask = mask_we ? mask_raw : '0;

    assert_update_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(vl_we && mask_we));

    assert_mask_shape_R5: assert property (@(posedge clk) disable iff (rst)
        mask_we |-> ((loaded_mask & (loaded_mask + MAX_ELEMS'(1))) == '0)
                    && ($countones(loaded_mask) == int'(done_count)));

    assert_idle_after_R12: assert property (@(posedge clk) disable iff (rst)
        (done || trap) |-> !busy && !mem_rd_valid);

endmodule

// File: tb/ffload_unit_tb.sv
`timescale 1ns/1ps
module ffload_unit_tb;
    localparam int ADDR_W = 16, DATA_W = 64, MAX_ELEMS = 8;
    localparam int PAGE_BYTES = 64, BATCH_BYTES = 16, REG_W = 5;
    localparam int CNT_W = 4, IDX_W = 3;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_report = 0;
    logic [ADDR_W-1:0] req_base = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic [1:0] req_esize = '0, req_mode = '0;
    logic [REG_W-1:0] req_dest = '0;
    logic busy, mem_rd_valid, mem_rd_fault, vrf_we, done, vl_we, mask_we, trap;
    logic mem_rd_ready = 0;
    logic [ADDR_W-1:0] mem_rd_addr, trap_addr;
    logic [1:0] mem_rd_size;
    logic [DATA_W-1:0] mem_rd_data, vrf_wdata;
    logic [REG_W-1:0] vrf_reg;
    logic [IDX_W-1:0] vrf_elem;
    logic [CNT_W-1:0] done_count, vl_value;
    logic [MAX_ELEMS-1:0] loaded_mask;

    logic fault_en = 0;
    int   fault_page = 0;
    int   checks = 0, fails = 0;

    always #2 clk = ~clk;

    assign mem_rd_fault = fault_en && (int'(mem_rd_addr >> 6) == fault_page);
    assign mem_rd_data  = {4{mem_rd_addr ^ 16'hA5C3}};

    ffload_unit #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_ELEMS(MAX_ELEMS),
        .PAGE_BYTES(PAGE_BYTES), .BATCH_BYTES(BATCH_BYTES), .REG_W(REG_W)
    ) u_dut (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_limit(int base, int esz, int cnt, int mode);
        int n = cnt;
        if (mode == 1) begin
            n = (PAGE_BYTES - (base % PAGE_BYTES)) >> esz;
            if (n == 0) n = 1;
        end else if (mode == 2 && (base % BATCH_BYTES) != 0) begin
            n = (BATCH_BYTES - (base % BATCH_BYTES)) >> esz;
            if (n == 0) n = 1;
        end
        return (cnt < n) ? cnt : n;
    endfunction

    function automatic logic [63:0] exp_data(int addr, int esz);
        logic [63:0] d = {4{16'(addr) ^ 16'hA5C3}};
        for (int b = 0; b < 8; b++) if (b >= (1 << esz)) d[b*8 +: 8] = 8'h00;
        return d;
    endfunction

    task automatic run_txn(int base, int esz, int cnt, int mode, bit rep,
                           bit fen, int fpage, bit stall, bit poke, int dest);
        int w = 1 << esz;
        int lim = exp_limit(base, esz, cnt, mode);
        int fidx = lim;
        int ecnt, ereads, nreads = 0, nwr = 0, last_hs = -1, end_it = -1;
        int bad_addr = 0, bad_wr = 0;
        bit etrap, got_done = 0, got_trap = 0, seen_vl = 0, seen_mask = 0;
        int got_cnt = 0, got_vl = 0, got_taddr = 0;
        logic [MAX_ELEMS-1:0] got_mask = '0;
        string tag;
        for (int i = 0; i < lim; i++)
            if (fen && fidx == lim && (((base + i * w) & 16'hFFFF) >> 6) == fpage) fidx = i;
        etrap  = (lim > 0) && (fidx == 0);
        ecnt   = etrap ? 0 : fidx;
        ereads = (fidx < lim) ? fidx + 1 : lim;
        tag = (cnt == 0) ? "R9" : etrap ? "R4" : (fidx < lim) ? "R3" :
              (mode == 1) ? "R6" : (mode == 2) ? "R7" : "R2";
        fault_en = fen; fault_page = fpage;
        @(negedge clk);
        req_valid = 1; req_base = 16'(base); req_count = 4'(cnt); req_esize = 2'(esz);
        req_mode = 2'(mode); req_report = rep; req_dest = 5'(dest);
        @(negedge clk);
        req_valid = 0;
        for (int it = 0; it < 60; it++) begin
            mem_rd_ready = stall ? ((it % 3) != 1) : 1'b1;
            if (poke && it == 0 && lim != 0) begin
                req_valid = 1; req_base = 16'(base + 1); req_count = 4'd1;
                req_mode = 2'd1; req_report = ~rep; req_dest = 5'(dest + 3);
            end else begin
                req_valid = 0;
            end
            #1;
            if (mem_rd_valid && mem_rd_ready) begin
                if (int'(mem_rd_addr) != ((base + nreads * w) & 16'hFFFF)) bad_addr++;
                if (int'(mem_rd_size) != esz) bad_addr++;
                nreads++; last_hs = it;
            end
            if (vrf_we) begin
                if (int'(vrf_reg) != dest || int'(vrf_elem) != nwr ||
                    vrf_wdata != exp_data((base + nwr * w) & 16'hFFFF, esz)) bad_wr++;
                nwr++;
            end
            if (done || trap) begin
                got_done = done; got_trap = trap; got_cnt = int'(done_count);
                seen_vl = vl_we; seen_mask = mask_we; got_vl = int'(vl_value);
                got_mask = loaded_mask; got_taddr = int'(trap_addr); end_it = it;
                if (trap && (done || vrf_we || vl_we || mask_we)) bad_wr++;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        req_valid = 0; mem_rd_ready = 0;
        #1;
        check(!busy && !mem_rd_valid && !done && !trap, "R12 idle after end", busy, 0);
        check(bad_addr == 0, "R1 R11 read address/size sequence", bad_addr, 0);
        check(bad_wr == 0, "R1 R11 element writes", bad_wr, 0);
        check(nreads == ereads, stall ? "R10 reads under stall" : "R3 read count", nreads, ereads);
        check(nwr == ecnt, "R3 R4 write count", nwr, ecnt);
        check(end_it == ((cnt == 0) ? 0 : last_hs + 1), "R2 completion timing", end_it, last_hs + 1);
        if (etrap) begin
            check(got_trap && !got_done, "R4 trap raised", got_trap, 1);
            check(got_taddr == base, "R4 trap address", got_taddr, base);
        end else begin
            check(got_done && !got_trap, {tag, " done raised"}, got_done, 1);
            check(got_cnt == ecnt, {tag, " R8 count"}, got_cnt, ecnt);
            if (rep) begin
                check(seen_mask && !seen_vl, "R5 mask strobe", seen_mask, 1);
                check(int'(got_mask) == ((1 << ecnt) - 1), "R5 mask value", got_mask, (1 << ecnt) - 1);
            end else begin
                check(seen_vl && !seen_mask, "R5 length strobe", seen_vl, 1);
                check(got_vl == ecnt, "R5 length value", got_vl, ecnt);
            end
        end
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int bases[6] = '{0, 6, 40, 52, 60, 63};
        int n = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(!busy && !mem_rd_valid && !vrf_we && !done && !trap && !vl_we && !mask_we,
              "R12 reset state", busy, 0);
        for (int esz = 0; esz < 4; esz++)
            for (int mode = 0; mode < 4; mode++)
                for (int bi = 0; bi < 6; bi++)
                    for (int cnt = 0; cnt <= MAX_ELEMS; cnt++)
                        for (int fc = 0; fc < 3; fc++) begin
                            int b = bases[bi];
                            int fp = (fc == 1) ? ((b + 2 * (1 << esz)) >> 6) : (b >> 6) + 1;
                            run_txn(b, esz, cnt, mode, cnt[0], fc != 0, fp,
                                    ((cnt + bi) % 3) == 0, n[0], (n % 29) + 1);
                            n++;
                        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule